// File: doc/BRIEF.md
# Line-Granular Memory Copy Engine

The engine copies a byte range of any length from a source address to a destination address. All traffic on its memory port is in whole cache lines. One command gives the source, the destination and the byte count. The engine walks the destination lines in order. Source and destination may sit at different offsets within a line, so for each destination line the engine builds the data from a window of two consecutive source lines. It then issues one line write per destination line.

In the default configuration each write carries a per-byte enable mask. A partial line at the start or end of the range is therefore written with only its covered bytes enabled, and the engine never reads a destination line. When `BYTE_EN` is 0, the engine first reads each partial destination line and merges the bytes outside the range into the write. Every write takes a write-buffer slot, tagged with the slot number. The slot stays taken until the cache acknowledges that tag. The acknowledgement also says whether the line arrived with an uncorrectable ECC error. The engine pulses `done` only after every write has been acknowledged. `done_err` rises with `done` if any acknowledgement for that command flagged an error.

Top module: `lcpy_engine`

## Requirements
- R1: Every memory request names one whole line (line address = byte address / LB). A request that is not yet accepted keeps its valid, line and direction until `mem_req_ready`.
- R2: After a command, every destination byte at `dst + k` (0 <= k < len) has been written with the source byte at `src + k`. This holds for any pair of source and destination offsets within a line.
- R3: With `BYTE_EN`=1 (default), bit i of `mem_req_be` enables byte i of the line, which is bits 8i+7..8i of `mem_req_wdata`. Bit i is set exactly when that byte lies inside the copy range. Fully covered lines carry all ones.
- R4: With `BYTE_EN`=1, no destination line is read. The number of reads per command equals the number of destination lines, plus one when (src - dst) mod LB is non-zero.
- R5: At most `WB_ENTRIES` writes are unacknowledged at any time. A further write waits until an acknowledgement frees a slot. `mem_req_tag` names the slot, and `mem_ack_tag` returns it.
- R6: `done` is not raised while any write of the command is unacknowledged.
- R7: A command with length 0 raises `done` in the cycle after it is accepted, and issues no memory request. While `cmd_ready` is high, no request is issued.
- R8: `done_err` is high with `done` exactly when at least one acknowledgement of that command had `mem_ack_ecc_err` set. It never stays set into the next command.
- R9: A copy that lies inside one destination line produces exactly one write, whose mask has both the head and the tail bytes cleared.
- R10: During reset `cmd_ready` is 1, and `mem_req_valid` and `done` are 0. `done` is a one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Engine idle, command accepted when valid |
| cmd_src | input | AW | Source byte address |
| cmd_dst | input | AW | Destination byte address |
| cmd_len | input | AW | Byte count |
| done | output | 1 | One-cycle completion pulse |
| done_err | output | 1 | ECC error seen during the command, valid with done |
| mem_req_valid | output | 1 | Line request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_we | output | 1 | 1 = line write, 0 = line read |
| mem_req_line | output | AW-log2(LB) | Line address |
| mem_req_wdata | output | 8*LB | Write line data |
| mem_req_be | output | LB | Per-byte write enables |
| mem_req_tag | output | log2(WB_ENTRIES) | Write-buffer slot of a write |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_rdata | input | 8*LB | Read line data |
| mem_ack_valid | input | 1 | Write acknowledgement |
| mem_ack_tag | input | log2(WB_ENTRIES) | Slot being acknowledged |
| mem_ack_ecc_err | input | 1 | Line arrived with uncorrectable error |

## Verification
The bench aims at offset mismatches between source and destination. An engine that shifted the window the wrong way, or that skipped the priming read, would write bytes taken from the wrong source line. It also covers head and tail masks, including a copy that sits inside a single line. A wrong mask would either clobber neighbouring bytes or drop covered ones. Slow acknowledgements fill the write buffer, which shows any engine that overruns its slots or retires before the last acknowledgement arrives. An ECC error injected on one command, followed by a clean command, catches an error flag that is lost or that lingers. A zero-length command catches an engine that issues a stray request or hangs.

// File: rtl/lcpy_pkg.sv
package lcpy_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_SRC,
    ST_WT_SRC,
    ST_RD_DST,
    ST_WT_DST,
    ST_WR,
    ST_DRAIN,
    ST_FIN
  } lcpy_state_e;
endpackage

// File: rtl/lcpy_mask.sv
module lcpy_mask #(
  parameter int LB = 64,
  localparam int OW = $clog2(LB)
) (
  input  logic          is_first,
  input  logic          is_last,
  input  logic [OW-1:0] head_off,
  input  logic [OW-1:0] tail_off,
  output logic [LB-1:0] mask
);
  for (genvar i = 0; i < LB; i++) begin : g_byte
    assign mask[i] = (!is_first || (OW'(i) >= head_off)) &&
                     (!is_last  || (OW'(i) <= tail_off));
  end
endmodule

// File: rtl/lcpy_align.sv
module lcpy_align #(
  parameter int LB = 64,
  localparam int OW = $clog2(LB),
  localparam int DW = 8 * LB
) (
  input  logic [DW-1:0] lo,
  input  logic [DW-1:0] hi,
  input  logic [OW-1:0] delta,
  output logic [DW-1:0] out
);
  logic [2*DW-1:0] window;
  assign window = {hi, lo};

  // delta 0: the newest line already is the aligned line
  always_comb begin
    if (delta == '0) out = hi;
    else             out = window[{delta, 3'b000} +: DW];
  end
endmodule

// File: rtl/lcpy_wbuf.sv
module lcpy_wbuf #(
  parameter int N = 4,
  localparam int TW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc,
  input  logic          ack_valid,
  input  logic [TW-1:0] ack_tag,
  output logic          full,
  output logic          empty,
  output logic [TW-1:0] free_tag
);
  logic [N-1:0] busy_q, busy_d;

  always_comb begin
    free_tag = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!busy_q[i]) free_tag = TW'(i);
    end
  end

  always_comb begin
    busy_d = busy_q;
    if (alloc)     busy_d[free_tag] = 1'b1;
    if (ack_valid) busy_d[ack_tag]  = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_q <= '0;
    else        busy_q <= busy_d;
  end

  assign full  = &busy_q;
  assign empty = ~|busy_q;
endmodule

// File: rtl/lcpy_engine.sv
module lcpy_engine
  import lcpy_pkg::*;
#(
  parameter int AW         = 32,
  parameter int LB         = 64,
  parameter int WB_ENTRIES = 4,
  parameter int BYTE_EN    = 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cmd_valid,
  output logic                         cmd_ready,
  input  logic [AW-1:0]                cmd_src,
  input  logic [AW-1:0]                cmd_dst,
  input  logic [AW-1:0]                cmd_len,
  output logic                         done,
  output logic                         done_err,
  output logic                         mem_req_valid,
  input  logic                         mem_req_ready,
  output logic                         mem_req_we,
  output logic [AW-$clog2(LB)-1:0]     mem_req_line,
  output logic [8*LB-1:0]              mem_req_wdata,
  output logic [LB-1:0]                mem_req_be,
  output logic [$clog2(WB_ENTRIES)-1:0] mem_req_tag,
  input  logic                         mem_rsp_valid,
  input  logic [8*LB-1:0]              mem_rsp_rdata,
  input  logic                         mem_ack_valid,
  input  logic [$clog2(WB_ENTRIES)-1:0] mem_ack_tag,
  input  logic                         mem_ack_ecc_err
);
  localparam int OW  = $clog2(LB);
  localparam int LAW = AW - OW;
  localparam int DW  = 8 * LB;
  localparam int TW  = $clog2(WB_ENTRIES);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  lcpy_state_e    st_q, st_d;
  logic [LAW-1:0] cur_q, cur_d, first_q, first_d, last_q, last_d, rd_q, rd_d;
  logic [OW-1:0]  dlt_q, dlt_d, hoff_q, hoff_d, toff_q, toff_d;
  logic           prime_q, prime_d, err_q, err_d;
  logic [DW-1:0]  lo_q, hi_q, dold_q, lo_nx;
  logic           lo_en, hi_en, dold_en;

  logic [AW-1:0]  end_addr, src_base;
  logic           wr_fire, is_first, is_last, partial, need_rmw;
  logic [LB-1:0]  line_mask;
  logic [DW-1:0]  bit_mask, aligned;
  logic           wb_full, wb_empty;
  logic [TW-1:0]  wb_tag;

  assign end_addr  = cmd_dst + cmd_len - AW'(1);
  assign src_base  = cmd_src - {{LAW{1'b0}}, cmd_dst[OW-1:0]};
  assign cmd_ready = (st_q == ST_IDLE);
  assign wr_fire   = mem_req_valid && mem_req_ready && mem_req_we;
  assign is_first  = (cur_q == first_q);
  assign is_last   = (cur_q == last_q);
  assign partial   = (is_first && hoff_q != '0) || (is_last && toff_q != OW'(LB - 1));
  assign need_rmw  = (BYTE_EN == 0) && partial;

  lcpy_mask #(.LB(LB)) u_mask (
    .is_first (is_first),
    .is_last  (is_last),
    .head_off (hoff_q),
    .tail_off (toff_q),
    .mask     (line_mask)
  );

  lcpy_align #(.LB(LB)) u_align (
    .lo    (lo_q),
    .hi    (hi_q),
    .delta (dlt_q),
    .out   (aligned)
  );

  lcpy_wbuf #(.N(WB_ENTRIES)) u_wbuf (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .alloc     (wr_fire),
    .ack_valid (mem_ack_valid),
    .ack_tag   (mem_ack_tag),
    .full      (wb_full),
    .empty     (wb_empty),
    .free_tag  (wb_tag)
  );

  for (genvar b = 0; b < LB; b++) begin : g_bits
    assign bit_mask[8*b +: 8] = {8{line_mask[b]}};
  end

  // next state
  always_comb begin
    st_d    = st_q;    cur_d  = cur_q;  first_d = first_q; last_d = last_q;
    rd_d    = rd_q;    dlt_d  = dlt_q;  hoff_d  = hoff_q;  toff_d = toff_q;
    prime_d = prime_q; err_d  = err_q;
    hi_en   = 1'b0;    lo_en  = 1'b0;   dold_en = 1'b0;    lo_nx  = hi_q;
    if (mem_ack_valid && mem_ack_ecc_err) err_d = 1'b1;
    case (st_q)
      ST_IDLE: if (cmd_valid) begin
        err_d = 1'b0;
        if (cmd_len == '0) begin
          st_d = ST_FIN;
        end else begin
          first_d = cmd_dst[AW-1:OW];
          cur_d   = cmd_dst[AW-1:OW];
          last_d  = end_addr[AW-1:OW];
          rd_d    = src_base[AW-1:OW];
          dlt_d   = src_base[OW-1:0];
          hoff_d  = cmd_dst[OW-1:0];
          toff_d  = end_addr[OW-1:0];
          prime_d = (src_base[OW-1:0] != '0);
          st_d    = ST_RD_SRC;
        end
      end
      ST_RD_SRC: if (mem_req_ready) begin
        rd_d = rd_q + LAW'(1);
        st_d = ST_WT_SRC;
      end
      ST_WT_SRC: if (mem_rsp_valid) begin
        hi_en = 1'b1;
        if (prime_q) begin
          lo_en   = 1'b1;
          lo_nx   = mem_rsp_rdata;
          prime_d = 1'b0;
          st_d    = ST_RD_SRC;
        end else if (need_rmw) begin
          st_d = ST_RD_DST;
        end else begin
          st_d = ST_WR;
        end
      end
      ST_RD_DST: if (mem_req_ready) st_d = ST_WT_DST;
      ST_WT_DST: if (mem_rsp_valid) begin
        dold_en = 1'b1;
        st_d    = ST_WR;
      end
      ST_WR: if (wr_fire) begin
        lo_en = 1'b1;
        if (is_last) begin
          st_d = ST_DRAIN;
        end else begin
          cur_d = cur_q + LAW'(1);
          st_d  = ST_RD_SRC;
        end
      end
      ST_DRAIN: if (wb_empty) st_d = ST_FIN;
      ST_FIN:   st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      st_q    <= ST_IDLE;
      cur_q   <= '0; first_q <= '0; last_q <= '0; rd_q <= '0;
      dlt_q   <= '0; hoff_q  <= '0; toff_q <= '0;
      prime_q <= 1'b0; err_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      cur_q   <= cur_d; first_q <= first_d; last_q <= last_d; rd_q <= rd_d;
      dlt_q   <= dlt_d; hoff_q  <= hoff_d;  toff_q <= toff_d;
      prime_q <= prime_d; err_q <= err_d;
    end
  end

  // line data registers, enabled only when loaded
  always_ff @(posedge clk) begin
    if (hi_en)   hi_q   <= mem_rsp_rdata;
    if (lo_en)   lo_q   <= lo_nx;
    if (dold_en) dold_q <= mem_rsp_rdata;
  end

  // request port
  always_comb begin
    mem_req_valid = 1'b0;
    mem_req_we    = 1'b0;
    mem_req_line  = cur_q;
    case (st_q)
      ST_RD_SRC: begin mem_req_valid = 1'b1; mem_req_line = rd_q; end
      ST_RD_DST: mem_req_valid = 1'b1;
      ST_WR:     begin mem_req_valid = !wb_full; mem_req_we = 1'b1; end
      default:   ;
    endcase
  end

  assign mem_req_wdata = (aligned & bit_mask) | (dold_q & ~bit_mask);
  assign mem_req_be    = (BYTE_EN != 0) ? line_mask : {LB{1'b1}};
  assign mem_req_tag   = wb_tag;
  assign done          = (st_q == ST_FIN);
  assign done_err      = done && err_q;
endmodule

// File: rtl/lcpy_engine_chk.sv
module lcpy_engine_chk #(
  parameter int LB  = 64,
  parameter int LAW = 26
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cmd_ready,
  input logic           done,
  input logic           done_err,
  input logic           mem_req_valid,
  input logic           mem_req_ready,
  input logic           mem_req_we,
  input logic [LAW-1:0] mem_req_line,
  input logic [LB-1:0]  mem_req_be,
  input logic           wb_empty
);
  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !mem_req_valid);

  a_r1_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_line) && $stable(mem_req_we)));

  a_r6_retire_drained: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> wb_empty);

  a_r8_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_err |-> done);

  a_r3_be_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_we) |-> (mem_req_be != '0));

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind lcpy_engine lcpy_engine_chk #(.LB(LB), .LAW(LAW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_sync_n),
  .cmd_ready     (cmd_ready),
  .done          (done),
  .done_err      (done_err),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_we    (mem_req_we),
  .mem_req_line  (mem_req_line),
  .mem_req_be    (mem_req_be),
  .wb_empty      (wb_empty)
);

// File: tb/lcpy_engine_tb.sv
module lcpy_engine_tb;
  localparam int AW = 32, LB = 64, WBN = 4, DW = 8 * LB;
  localparam int LAW = AW - $clog2(LB), TW = $clog2(WBN), MEMB = 8192;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [AW-1:0] cmd_src = '0, cmd_dst = '0, cmd_len = '0;
  logic cmd_ready, done, done_err;
  logic mem_req_valid, mem_req_we;
  logic mem_req_ready = 1'b0;
  logic [LAW-1:0] mem_req_line;
  logic [DW-1:0] mem_req_wdata;
  logic [LB-1:0] mem_req_be;
  logic [TW-1:0] mem_req_tag;
  logic mem_rsp_valid = 1'b0;
  logic [DW-1:0] mem_rsp_rdata = '0;
  logic mem_ack_valid = 1'b0, mem_ack_ecc_err = 1'b0;
  logic [TW-1:0] mem_ack_tag = '0;

  lcpy_engine #(.AW(AW), .LB(LB), .WB_ENTRIES(WBN), .BYTE_EN(1)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_src(cmd_src), .cmd_dst(cmd_dst), .cmd_len(cmd_len),
    .done(done), .done_err(done_err),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_line(mem_req_line),
    .mem_req_wdata(mem_req_wdata), .mem_req_be(mem_req_be),
    .mem_req_tag(mem_req_tag), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_rdata(mem_rsp_rdata), .mem_ack_valid(mem_ack_valid),
    .mem_ack_tag(mem_ack_tag), .mem_ack_ecc_err(mem_ack_ecc_err)
  );

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  longint cyc = 0;
  logic [7:0] mem [0:MEMB-1];

  typedef struct {
    logic [LAW-1:0] line;
    logic [LB-1:0]  be;
    logic [DW-1:0]  data;
  } exp_t;
  exp_t exp_q[$];

  typedef struct {
    logic [TW-1:0] tag;
    longint        due;
    logic          err;
  } ack_t;
  ack_t ack_q[$];

  int ack_lat = 2, err_idx = -1, mdl_wr = 0, rd_wait = 0;
  logic [LAW-1:0] rd_line_m;
  int wr_seen = 0, rd_seen = 0, outst = 0, max_outst = 0;
  bit dst_read = 0;
  int dfirst = 0, dlast = -1;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic [DW-1:0] get_line(input int ln);
    logic [DW-1:0] v;
    for (int b = 0; b < LB; b++) v[8*b +: 8] = mem[(ln * LB + b) % MEMB];
    return v;
  endfunction

  // memory model: accepts on edges, writes with byte enables, acks in order
  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_req_ready <= (cyc % 3) != 1;
    if (rd_wait == 1) begin
      mem_rsp_valid <= 1'b1;
      mem_rsp_rdata <= get_line(int'(rd_line_m));
    end else begin
      mem_rsp_valid <= 1'b0;
    end
    if (rd_wait > 0) rd_wait <= rd_wait - 1;
    if (mem_req_valid && mem_req_ready) begin
      if (mem_req_we) begin
        for (int b = 0; b < LB; b++)
          if (mem_req_be[b]) mem[(int'(mem_req_line) * LB + b) % MEMB] <= mem_req_wdata[8*b +: 8];
        ack_q.push_back('{mem_req_tag, cyc + ack_lat, (mdl_wr == err_idx)});
        mdl_wr <= mdl_wr + 1;
      end else begin
        rd_wait   <= 2;
        rd_line_m <= mem_req_line;
      end
    end
    if (ack_q.size() > 0 && ack_q[0].due <= cyc) begin
      mem_ack_valid   <= 1'b1;
      mem_ack_tag     <= ack_q[0].tag;
      mem_ack_ecc_err <= ack_q[0].err;
      void'(ack_q.pop_front());
    end else begin
      mem_ack_valid   <= 1'b0;
      mem_ack_ecc_err <= 1'b0;
    end
  end

  // monitor: scoreboard pop on every write handshake
  always @(negedge clk) begin
    exp_t e;
    logic [DW-1:0] bm;
    if (rst_n && mem_req_valid && mem_req_ready) begin
      if (mem_req_we) begin
        wr_seen++;
        outst++;
        if (outst > max_outst) max_outst = outst;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2 unexpected write", 64'(mem_req_line), 0);
        end else begin
          e = exp_q.pop_front();
          for (int b = 0; b < LB; b++) bm[8*b +: 8] = {8{e.be[b]}};
          chk(mem_req_line == e.line, "R1 write line", 64'(mem_req_line), 64'(e.line));
          chk(mem_req_be == e.be, "R3 byte mask", 64'(mem_req_be), 64'(e.be));
          chk(((mem_req_wdata ^ e.data) & bm) == '0, "R2 line data",
              mem_req_wdata[63:0], e.data[63:0]);
        end
      end else begin
        rd_seen++;
        if (int'(mem_req_line) >= dfirst && int'(mem_req_line) <= dlast) dst_read = 1;
      end
    end
    if (mem_ack_valid) outst--;
  end

  // driver: builds the expected lines, then issues the command and waits
  task automatic run_cmd(input int src, input int dst, input int len, input int lat,
                         input int eidx, input bit exp_err, input string name);
    int first, last, nl, exp_rd, t;
    ack_lat = lat; err_idx = eidx; mdl_wr = 0;
    wr_seen = 0; rd_seen = 0; max_outst = 0; dst_read = 0;
    if (len != 0) begin
      first = dst / LB; last = (dst + len - 1) / LB;
      dfirst = first; dlast = last;
      for (int l = first; l <= last; l++) begin
        exp_t e;
        e.line = LAW'(l); e.be = '0; e.data = '0;
        for (int b = 0; b < LB; b++) begin
          int a;
          a = l * LB + b;
          if (a >= dst && a < dst + len) begin
            e.be[b] = 1'b1;
            e.data[8*b +: 8] = mem[(src + (a - dst)) % MEMB];
          end
        end
        exp_q.push_back(e);
      end
      nl = last - first + 1;
      exp_rd = nl + ((((src - dst) % LB) != 0) ? 1 : 0);
    end else begin
      dfirst = 0; dlast = -1; nl = 0; exp_rd = 0;
    end
    @(negedge clk);
    cmd_src = AW'(src); cmd_dst = AW'(dst); cmd_len = AW'(len); cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    t = 0;
    while (!done && t < 5000) begin @(negedge clk); t++; end
    chk(t < 5000, {"R6 completion ", name}, 64'(t), 0);
    if (len == 0) chk(t == 0, {"R7 zero-length latency ", name}, 64'(t), 0);
    chk(done_err == exp_err, {"R8 error status ", name}, 64'(done_err), 64'(exp_err));
    chk(outst == 0, {"R6 acks outstanding at done ", name}, 64'(outst), 0);
    chk(exp_q.size() == 0, {"R2 lines left unwritten ", name}, 64'(exp_q.size()), 0);
    chk(wr_seen == nl, {"R9 write count ", name}, 64'(wr_seen), 64'(nl));
    chk(rd_seen == exp_rd, {"R4 read count ", name}, 64'(rd_seen), 64'(exp_rd));
    chk(!dst_read, {"R4 destination read ", name}, 64'(dst_read), 0);
    chk(max_outst <= WBN, {"R5 slots exceeded ", name}, 64'(max_outst), 64'(WBN));
    exp_q.delete();
    @(negedge clk);
    chk(!done, {"R10 done pulse ", name}, 64'(done), 0);
  endtask

  task automatic summary;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  always @(negedge clk) begin
    if (cyc == 150000) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < MEMB; i++) mem[i] = 8'((i * 7 + 3) ^ (i >> 8));
    repeat (3) @(negedge clk);
    chk(cmd_ready == 1'b1, "R10 reset cmd_ready", 64'(cmd_ready), 1);
    chk(mem_req_valid == 1'b0, "R10 reset no request", 64'(mem_req_valid), 0);
    chk(done == 1'b0, "R10 reset done", 64'(done), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    run_cmd('h100, 'h800, 128, 2, -1, 0, "aligned");
    run_cmd('h105, 'h913, 200, 2, -1, 0, "both-offset");
    run_cmd('h203, 'hA21, 10, 3, -1, 0, "single-line");
    run_cmd('h300, 'hB00, 0, 2, -1, 0, "zero-length");
    chk(wr_seen == 0 && rd_seen == 0, "R7 zero-length requests", 64'(wr_seen + rd_seen), 0);
    run_cmd('h040, 'hC05, 64, 2, -1, 0, "dst-offset");
    run_cmd('h400, 'h1000, 640, 30, -1, 0, "slow-ack");
    chk(max_outst == WBN, "R5 buffer fills under slow acks", 64'(max_outst), 64'(WBN));
    run_cmd('h500, 'h1400, 150, 4, 1, 1, "ecc-error");
    run_cmd('h600, 'h1633, 70, 2, -1, 0, "after-error");

    summary();
    $finish;
  end
endmodule